// File: doc/BRIEF.md
# Split-Half GPIO Register Bank

This block puts a 32-bit general-purpose output latch and a 32-bit input port behind a narrow register bus. Software reaches each port as two 16-bit registers, one for bits 15:0 and one for bits 31:16. Each value sits right-justified in the 32-bit data word. A write to one half leaves the other half as it was.

Some fixed side functions share the same bank:
- A status view returns the complement of each input half.
- A 6-bit LCD brightness level is built from two registers. Its low three bits come from a spare output-enable register. Its high three bits are copied from output bits 18:16 whenever the upper output half is written.
- Output bits 29 and 30 drive the data and clock pins of a bit-banged I2C bus.
- The live I2C data pin replaces bit 29 when the upper input half is read.
- A constant board revision register completes the bank.

Reads are returned one cycle after the request from a registered data output. A write to the upper output half also produces a one-cycle strobe, which tells an attached bit-bang engine that a new clock/data pair is present.

Top module: `gpio_split_bank`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `gpio_out`, `lcd_level`, `bus_rdata`, `bus_rvalid` and `i2c_strobe` are all zero.
- R2: A write to offset 0xD00C loads `bus_wdata[15:0]` into `gpio_out[15:0]` and leaves `gpio_out[31:16]` unchanged. The new value is visible on the cycle after the write.
- R3: A write to offset 0xD50C loads `bus_wdata[15:0]` into `gpio_out[31:16]` and leaves `gpio_out[15:0]` unchanged.
- R4: A read of 0xD00C returns `gpio_out[15:0]` and a read of 0xD50C returns `gpio_out[31:16]`. In both cases `bus_rdata[31:16]` is zero.
- R5: A read of 0xD010 returns `gpio_in[15:0]` and a read of 0xD510 returns `gpio_in[31:16]`, both right-justified. In the upper read, bit 13 (port bit 29) is replaced by `i2c_sda_in`.
- R6: A read of 0xD020 returns `~gpio_in[15:0]` and a read of 0xD520 returns `~gpio_in[31:16]`, taken from the raw pins with zero in bits 31:16.
- R7: A write to 0xD508 stores only `bus_wdata[2:0]`. That value drives `lcd_level[2:0]` and is returned by a read of 0xD508, with all other bits zero.
- R8: A write to 0xD50C copies `bus_wdata[2:0]` (output bits 18:16) into `lcd_level[5:3]`. No other write changes `lcd_level[5:3]`.
- R9: `i2c_sda_out` follows `gpio_out[29]` and `i2c_scl_out` follows `gpio_out[30]`. `i2c_strobe` is high for exactly the cycle after each write to 0xD50C.
- R10: A read of 0x2018 returns 0x00000031. Any other offset not listed here reads as zero, and writes to it change nothing.
- R11: `bus_rvalid` is high on exactly the cycle after a cycle with `bus_rd` high, and `bus_rdata` then holds the requested value. On other cycles `bus_rdata` is zero. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| gpio_in | input | 32 | Input port pins |
| i2c_sda_in | input | 1 | Live I2C data pin level |
| gpio_out | output | 32 | Output latch |
| lcd_level | output | 6 | Brightness: [5:3] from output copy, [2:0] from enable register |
| i2c_sda_out | output | 1 | I2C data drive (output bit 29) |
| i2c_scl_out | output | 1 | I2C clock drive (output bit 30) |
| i2c_strobe | output | 1 | One-cycle pulse after an upper output write |

## Verification
Every registered result is due exactly one clock edge after its stimulus:
- latch halves, brightness fields and the I2C pins change on the edge that takes the write;
- `i2c_strobe`, `bus_rvalid` and `bus_rdata` answer the request of the previous cycle.

The bench drives each request half a period before an edge and updates its reference model on that edge. It then compares every output against the model at the following falling edge, so each comparison lands on the first cycle where the result must be visible. A read issued together with a write is modelled from the state before the write, which checks the ordering in R11.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;

    localparam int OFS_REVISION = 'h2018;
    localparam int OFS_OUT_LO   = 'hD00C;
    localparam int OFS_IN_LO    = 'hD010;
    localparam int OFS_STAT_LO  = 'hD020;
    localparam int OFS_OE_HI    = 'hD508;
    localparam int OFS_OUT_HI   = 'hD50C;
    localparam int OFS_IN_HI    = 'hD510;
    localparam int OFS_STAT_HI  = 'hD520;

    localparam int BOARD_REV    = 'h0031;

    // port bit positions with behavioural meaning
    localparam int SDA_BIT      = 29;
    localparam int SCL_BIT      = 30;
    localparam int BRIGHT_LSB   = 16;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_split_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   out_q,
    output logic                  hi_strobe
);

    localparam int NUM_HALVES = 2;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam int HALF_OFS = (h == 0) ? OFS_OUT_LO : OFS_OUT_HI;
        logic sel;

        assign sel = wr && (addr == ADDR_W'(HALF_OFS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[h*HALF_W +: HALF_W] <= '0;
            end else if (sel) begin
                out_q[h*HALF_W +: HALF_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_strobe <= 1'b0;
        end else begin
            hi_strobe <= wr && (addr == ADDR_W'(OFS_OUT_HI));
        end
    end

endmodule

// File: rtl/gpio_bright_reg.sv
module gpio_bright_reg
    import gpio_split_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BRIGHT_W = 3,
    parameter int HALF_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BRIGHT_W-1:0]   wdata_lo,
    output logic [BRIGHT_W-1:0]   oe_bits,
    output logic [BRIGHT_W-1:0]   copy_bits
);

    // the copied field sits at output bit BRIGHT_LSB, inside the upper half
    localparam int COPY_POS = BRIGHT_LSB - HALF_W;

    logic oe_sel;
    logic hi_sel;

    assign oe_sel = wr && (addr == ADDR_W'(OFS_OE_HI));
    assign hi_sel = wr && (addr == ADDR_W'(OFS_OUT_HI)) && (COPY_POS == 0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_bits   <= '0;
            copy_bits <= '0;
        end else begin
            if (oe_sel) oe_bits   <= wdata_lo;
            if (hi_sel) copy_bits <= wdata_lo;
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_split_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int HALF_W   = 16,
    parameter int BRIGHT_W = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*HALF_W-1:0]   out_q,
    input  logic [2*HALF_W-1:0]   pins_in,
    input  logic                  sda_in,
    input  logic [BRIGHT_W-1:0]   oe_bits,
    output logic [DATA_W-1:0]     value
);

    localparam int SDA_IN_POS = SDA_BIT - HALF_W;

    logic [HALF_W-1:0] in_hi_merged;

    always_comb begin
        in_hi_merged             = pins_in[2*HALF_W-1:HALF_W];
        in_hi_merged[SDA_IN_POS] = sda_in;
    end

    always_comb begin
        value = '0;
        unique case (int'(addr))
            OFS_OUT_LO:   value[HALF_W-1:0]   = out_q[HALF_W-1:0];
            OFS_OUT_HI:   value[HALF_W-1:0]   = out_q[2*HALF_W-1:HALF_W];
            OFS_IN_LO:    value[HALF_W-1:0]   = pins_in[HALF_W-1:0];
            OFS_IN_HI:    value[HALF_W-1:0]   = in_hi_merged;
            OFS_STAT_LO:  value[HALF_W-1:0]   = ~pins_in[HALF_W-1:0];
            OFS_STAT_HI:  value[HALF_W-1:0]   = ~pins_in[2*HALF_W-1:HALF_W];
            OFS_OE_HI:    value[BRIGHT_W-1:0] = oe_bits;
            OFS_REVISION: value               = DATA_W'(BOARD_REV);
            default:      value               = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_split_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd)  state_d = BUS_RESP;
            BUS_RESP: if (!rd) state_d = BUS_IDLE;
            default:           state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (state_d == BUS_RESP) begin
            rdata <= rd_value;
        end else begin
            rdata <= '0;
        end
    end

    assign rvalid = (state_q == BUS_RESP);

endmodule

// File: rtl/gpio_split_bank.sv
module gpio_split_bank
    import gpio_split_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int PORT_W   = 32,
    parameter int BRIGHT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    input  logic [PORT_W-1:0]       gpio_in,
    input  logic                    i2c_sda_in,
    output logic [PORT_W-1:0]       gpio_out,
    output logic [2*BRIGHT_W-1:0]   lcd_level,
    output logic                    i2c_sda_out,
    output logic                    i2c_scl_out,
    output logic                    i2c_strobe
);

    localparam int HALF_W = PORT_W / 2;

    logic [BRIGHT_W-1:0] oe_bits;
    logic [BRIGHT_W-1:0] copy_bits;
    logic [DATA_W-1:0]   rd_value;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:HALF_W];

    gpio_out_latch #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata[HALF_W-1:0]),
        .out_q     (gpio_out),
        .hi_strobe (i2c_strobe)
    );

    gpio_bright_reg #(.ADDR_W(ADDR_W), .BRIGHT_W(BRIGHT_W), .HALF_W(HALF_W)) u_bright (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata_lo  (bus_wdata[BRIGHT_W-1:0]),
        .oe_bits   (oe_bits),
        .copy_bits (copy_bits)
    );

    gpio_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W),
                    .BRIGHT_W(BRIGHT_W)) u_mux (
        .addr    (bus_addr),
        .out_q   (gpio_out),
        .pins_in (gpio_in),
        .sda_in  (i2c_sda_in),
        .oe_bits (oe_bits),
        .value   (rd_value)
    );

    gpio_bus_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .rd_value (rd_value),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    assign lcd_level   = {copy_bits, oe_bits};
    assign i2c_sda_out = gpio_out[SDA_BIT];
    assign i2c_scl_out = gpio_out[SCL_BIT];

endmodule

// File: rtl/gpio_split_checker.sv
module gpio_split_checker
    import gpio_split_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int PORT_W   = 32,
    parameter int BRIGHT_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic                  bus_rvalid,
    input logic [PORT_W-1:0]     gpio_out,
    input logic [2*BRIGHT_W-1:0] lcd_level,
    input logic                  i2c_strobe
);

    localparam int HALF_W = PORT_W / 2;

    logic hi_wr;
    logic lo_wr;
    logic known_addr;

    assign hi_wr = bus_wr && (bus_addr == ADDR_W'(OFS_OUT_HI));
    assign lo_wr = bus_wr && (bus_addr == ADDR_W'(OFS_OUT_LO));
    assign known_addr = (bus_addr == ADDR_W'(OFS_OUT_LO))  || (bus_addr == ADDR_W'(OFS_OUT_HI)) ||
                        (bus_addr == ADDR_W'(OFS_IN_LO))   || (bus_addr == ADDR_W'(OFS_IN_HI))  ||
                        (bus_addr == ADDR_W'(OFS_STAT_LO)) || (bus_addr == ADDR_W'(OFS_STAT_HI)) ||
                        (bus_addr == ADDR_W'(OFS_OE_HI))   || (bus_addr == ADDR_W'(OFS_REVISION));

    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (!bus_rvalid && bus_rdata == '0));

    assert_strobe_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> i2c_strobe);

    assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> !i2c_strobe);

    assert_low_write_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> $stable(gpio_out[PORT_W-1:HALF_W]));

    assert_high_write_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> $stable(gpio_out[HALF_W-1:0]));

    assert_unmapped_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !known_addr) |=> ($stable(gpio_out) && $stable(lcd_level)));

    assert_revision_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_REVISION)) |=> (bus_rdata == DATA_W'(BOARD_REV)));

    assert_copy_only_on_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> $stable(lcd_level[2*BRIGHT_W-1:BRIGHT_W]));

endmodule

bind gpio_split_bank gpio_split_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .BRIGHT_W(BRIGHT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .gpio_out   (gpio_out),
    .lcd_level  (lcd_level),
    .i2c_strobe (i2c_strobe)
);

// File: tb/gpio_split_bank_test.sv
module gpio_split_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] gpio_in = '0;
    logic        i2c_sda_in = 1'b0;
    logic [31:0] gpio_out;
    logic [5:0]  lcd_level;
    logic        i2c_sda_out;
    logic        i2c_scl_out;
    logic        i2c_strobe;

    int compared = 0;
    int mismatched = 0;
    bit check_en = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_out;
    logic [2:0]  m_oe;
    logic [2:0]  m_copy;
    logic        m_strobe;
    logic        m_rvalid;
    logic [31:0] m_rdata;

    always #10 clk = ~clk;

    gpio_split_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .gpio_in(gpio_in), .i2c_sda_in(i2c_sda_in),
        .gpio_out(gpio_out), .lcd_level(lcd_level), .i2c_sda_out(i2c_sda_out),
        .i2c_scl_out(i2c_scl_out), .i2c_strobe(i2c_strobe)
    );

    function automatic logic [31:0] model_read(input logic [15:0] a);
        logic [31:0] hi_in;
        hi_in = {16'h0, gpio_in[31:16]};
        hi_in[13] = i2c_sda_in;
        case (a)
            16'hD00C: return {16'h0, m_out[15:0]};
            16'hD50C: return {16'h0, m_out[31:16]};
            16'hD010: return {16'h0, gpio_in[15:0]};
            16'hD510: return hi_in;
            16'hD020: return {16'h0, ~gpio_in[15:0]};
            16'hD520: return {16'h0, ~gpio_in[31:16]};
            16'hD508: return {29'h0, m_oe};
            16'h2018: return 32'h31;
            default:  return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = '0; m_oe = '0; m_copy = '0;
            m_strobe = 1'b0; m_rvalid = 1'b0; m_rdata = '0;
        end else begin
            m_rvalid = bus_rd;
            m_rdata  = bus_rd ? model_read(bus_addr) : 32'h0;
            m_strobe = bus_wr && bus_addr == 16'hD50C;
            if (bus_wr) begin
                case (bus_addr)
                    16'hD00C: m_out[15:0] = bus_wdata[15:0];
                    16'hD50C: begin
                        m_out[31:16] = bus_wdata[15:0];
                        m_copy = bus_wdata[2:0];
                    end
                    16'hD508: m_oe = bus_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (check_en && !done) begin
            chk("R2/R3", "gpio_out", gpio_out, m_out);
            chk("R7", "lcd_level[2:0]", {29'h0, lcd_level[2:0]}, {29'h0, m_oe});
            chk("R8", "lcd_level[5:3]", {29'h0, lcd_level[5:3]}, {29'h0, m_copy});
            chk("R9", "i2c_sda_out", {31'h0, i2c_sda_out}, {31'h0, m_out[29]});
            chk("R9", "i2c_scl_out", {31'h0, i2c_scl_out}, {31'h0, m_out[30]});
            chk("R9", "i2c_strobe", {31'h0, i2c_strobe}, {31'h0, m_strobe});
            chk("R11", "bus_rvalid", {31'h0, bus_rvalid}, {31'h0, m_rvalid});
            chk("R4/R5/R6/R10/R11", "bus_rdata", bus_rdata, m_rdata);
        end
    end

    task automatic op(input bit w, input bit r, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] addrs [10];
        addrs = '{16'hD00C, 16'hD50C, 16'hD010, 16'hD510, 16'hD020,
                  16'hD520, 16'hD508, 16'h2018, 16'hD000, 16'h0004};
        repeat (3) @(negedge clk);
        // R1: outputs zero while in reset
        chk("R1", "gpio_out in reset", gpio_out, 32'h0);
        chk("R1", "rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
        chk("R1", "lcd_level in reset", {26'h0, lcd_level}, 32'h0);
        rst_n = 1'b1;
        check_en = 1'b1;
        @(negedge clk);
        // R2: low half write, upper bits of wdata ignored
        op(1, 0, 16'hD00C, 32'hA5A5_1234);
        op(0, 1, 16'hD00C, 0);
        // R3, R8, R9: high half write sets bit 30, bit 29 and bits 18:16
        op(1, 0, 16'hD50C, 32'hFFFF_6005);
        op(0, 1, 16'hD50C, 0);
        op(1, 0, 16'hD50C, 32'h0000_2002);
        // R5: input halves with sda merge
        gpio_in = 32'h1234_ABCD; i2c_sda_in = 1'b0;
        op(0, 1, 16'hD010, 0);
        op(0, 1, 16'hD510, 0);
        gpio_in = 32'hC000_0001; i2c_sda_in = 1'b1;
        op(0, 1, 16'hD510, 0);
        // R6: status complement
        op(0, 1, 16'hD020, 0);
        op(0, 1, 16'hD520, 0);
        // R7: OE register keeps three bits
        op(1, 0, 16'hD508, 32'hFFFF_FFFE);
        op(0, 1, 16'hD508, 0);
        // R10: revision and unmapped
        op(0, 1, 16'h2018, 0);
        op(1, 0, 16'hD000, 32'hFFFF_FFFF);
        op(0, 1, 16'hD000, 0);
        // R11: back-to-back reads and read with write in same cycle
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 16'hD00C;
        @(negedge clk);
        bus_addr = 16'h2018;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'hD00C; bus_wdata = 32'h0000_BEEF;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_wr = $urandom_range(0, 1) == 1;
            bus_rd = $urandom_range(0, 1) == 1;
            bus_addr = addrs[$urandom_range(0, 9)];
            bus_wdata = $urandom;
            gpio_in = $urandom;
            i2c_sda_in = $urandom_range(0, 1) == 1;
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule